// File: doc/BRIEF.md
# Transmit Interframe-Gap Deferral Timer

This block decides when a transmit MAC on a nibble-wide media-independent interface may begin a frame after the line has been busy. Whenever carrier or receive-valid activity ends, or the block's own transmission ends, it times a gap made of three phases in sequence: an optional lead-in phase, a deferring phase and a committed phase. Each phase length is a programmable count of interface clock periods. During the lead-in and deferring phases, renewed carrier abandons the gap, and timing restarts once carrier falls again. During the committed phase, carrier is disregarded.

A mode input selects whether the lead-in phase is timed at all. Software normally drives it from a transceiver configuration register. The mode is sampled only when a gap begins, so a change mid-gap has no effect until the next gap. The block reports two things: a level saying transmission may start, and a level saying it is currently deferring. When the transmit request rises while transmission is permitted, the block treats this as the start of a frame. It leaves both states and waits for the request to fall before timing the next gap.

Top module: `ipg_defer_timer`

## Requirements
- R1: A synchronous active-high reset makes `tx_ok_o` 1 and `defer_o` 0 from the first clock edge after it, with no phase running.
- R2: While permitted, carrier sampled high at a clock edge makes `tx_ok_o` 0 and `defer_o` 1 after that edge. The two outputs are never both 1.
- R3: With mode 1, counting the clock edge that first samples carrier low as edge 1, `tx_ok_o` rises after edge L0+L1+L2+1. Here L0, L1 and L2 are the three phase lengths.
- R4: With mode 0, the lead-in length is ignored and `tx_ok_o` rises after edge L1+L2+1.
- R5: Carrier sampled high during the lead-in or deferring phase returns the timer to deferring-on-carrier. The full gap is then timed again from the next fall of carrier.
- R6: Carrier sampled high during the committed phase neither restarts nor extends the gap. `defer_o` stays 1 until the gap ends on its original schedule.
- R7: A phase length of zero adds no cycles to the gap. If every timed phase is zero, `tx_ok_o` rises after edge 1.
- R8: If `tx_req_i` is sampled high while permitted and carrier is low, both outputs are 0 after that edge. Carrier is then ignored until `tx_req_i` falls, and the gap timing of R3/R4 starts at the edge that samples `tx_req_i` low.
- R9: The mode is sampled only at the edge that starts a gap. Changing it during a gap does not change that gap's length.
- R10: Once permitted, `tx_ok_o` stays 1 for as long as carrier and `tx_req_i` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock, one nibble time per period |
| rst | input | 1 | Synchronous active-high reset |
| carrier_i | input | 1 | Carrier sense or receive-valid activity |
| gap0_len_i | input | CNT_W | Lead-in phase length in clock periods |
| gap1_len_i | input | CNT_W | Deferring phase length in clock periods |
| gap2_len_i | input | CNT_W | Committed phase length in clock periods |
| ext_mode_i | input | 1 | 1: time the lead-in phase; 0: skip it |
| tx_req_i | input | 1 | Transmit request; a high level while permitted starts a frame |
| tx_ok_o | output | 1 | Transmission permitted |
| defer_o | output | 1 | Timer is deferring or timing a gap |

## Verification
The gap length is swept over every combination of phase lengths from 0 to 3 in both modes, plus a long mixed case. Each measured edge count is compared with the arithmetic sum, which separates a wrongly counted lead-in, an off-by-one phase and a zero length that costs a cycle. Carrier pulses placed inside the lead-in, deferring and committed phases show whether a restart happens in the phases that defer and does not happen in the phase that does not. A mode flip in mid-gap, a transmit request with carrier raised during the frame, and a long idle hold check that the mode is sampled once, that carrier is ignored while transmitting, and that permission persists.

// File: rtl/ipg_defer_pkg.sv
package ipg_defer_pkg;

   localparam int NUM_PHASES = 3;

   typedef enum logic [2:0] {
      ST_OK   = 3'd0,
      ST_WAIT = 3'd1,
      ST_PH0  = 3'd2,
      ST_PH1  = 3'd3,
      ST_PH2  = 3'd4,
      ST_TX   = 3'd5
   } ipg_state_e;

   function automatic ipg_state_e phase_state(input int idx);
      case (idx)
         0:       return ST_PH0;
         1:       return ST_PH1;
         default: return ST_PH2;
      endcase
   endfunction

endpackage

// File: rtl/ipg_phase_sel.sv
// Finds the first phase at or after from_idx whose length is nonzero.
// A from_idx past the last phase, or all-zero remaining phases, yields ST_OK.
module ipg_phase_sel
   import ipg_defer_pkg::*;
#(
   parameter int CNT_W = 8,
   localparam int IDX_W = $clog2(NUM_PHASES + 1)
) (
   input  logic [NUM_PHASES-1:0][CNT_W-1:0] lens_i,
   input  logic [IDX_W-1:0]                 from_idx_i,
   output ipg_state_e                       next_st_o,
   output logic [CNT_W-1:0]                 next_len_o
);

   logic [NUM_PHASES-1:0] nonzero;

   for (genvar g = 0; g < NUM_PHASES; g++) begin : g_nz
      assign nonzero[g] = |lens_i[g];
   end

   always_comb begin
      logic found;
      found      = 1'b0;
      next_st_o  = ST_OK;
      next_len_o = '0;
      for (int i = 0; i < NUM_PHASES; i++) begin
         if (!found && (i >= int'(from_idx_i)) && nonzero[i]) begin
            found      = 1'b1;
            next_st_o  = phase_state(i);
            next_len_o = lens_i[i];
         end
      end
   end

endmodule

// File: rtl/ipg_phase_counter.sv
// Remaining-cycles counter for the running phase.
module ipg_phase_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec_i)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R3: the controller never asks for a decrement past zero
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
      dec_i |-> !zero_o);

endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer
   import ipg_defer_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             carrier_i,
   input  logic [CNT_W-1:0] gap0_len_i,
   input  logic [CNT_W-1:0] gap1_len_i,
   input  logic [CNT_W-1:0] gap2_len_i,
   input  logic             ext_mode_i,
   input  logic             tx_req_i,
   output logic             tx_ok_o,
   output logic             defer_o
);

   localparam int IDX_W = $clog2(NUM_PHASES + 1);

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
      $error("ipg_defer_timer: CNT_W must be 1..16");
   end

   ipg_state_e state_q, state_d;
   logic [NUM_PHASES-1:0][CNT_W-1:0] lens;
   logic [IDX_W-1:0] start_idx, adv_idx;
   ipg_state_e start_st, adv_st;
   logic [CNT_W-1:0] start_len, adv_len;
   logic cnt_load, cnt_dec, cnt_zero;
   logic [CNT_W-1:0] cnt_val;

   assign lens = {gap2_len_i, gap1_len_i, gap0_len_i};

   // gap entry: lead-in only when the mode asks for it
   assign start_idx = ext_mode_i ? IDX_W'(0) : IDX_W'(1);

   always_comb begin
      case (state_q)
         ST_PH0:  adv_idx = IDX_W'(1);
         ST_PH1:  adv_idx = IDX_W'(2);
         default: adv_idx = IDX_W'(NUM_PHASES);
      endcase
   end

   ipg_phase_sel #(.CNT_W(CNT_W)) u_sel_start (
      .lens_i(lens), .from_idx_i(start_idx),
      .next_st_o(start_st), .next_len_o(start_len));

   ipg_phase_sel #(.CNT_W(CNT_W)) u_sel_adv (
      .lens_i(lens), .from_idx_i(adv_idx),
      .next_st_o(adv_st), .next_len_o(adv_len));

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      cnt_dec  = 1'b0;
      cnt_val  = start_len - 1'b1;
      case (state_q)
         ST_OK: begin
            if (carrier_i)     state_d = ST_WAIT;
            else if (tx_req_i) state_d = ST_TX;
         end
         ST_WAIT, ST_TX: begin
            if ((state_q == ST_WAIT) ? !carrier_i : !tx_req_i) begin
               state_d  = start_st;
               cnt_load = 1'b1;
            end
         end
         ST_PH0, ST_PH1, ST_PH2: begin
            if (carrier_i && state_q != ST_PH2) begin
               state_d = ST_WAIT;
            end else if (cnt_zero) begin
               state_d  = adv_st;
               cnt_load = 1'b1;
               cnt_val  = adv_len - 1'b1;
            end else begin
               cnt_dec = 1'b1;
            end
         end
         default: state_d = ST_OK;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_OK;
      else     state_q <= state_d;
   end

   ipg_phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load_i(cnt_load), .load_val_i(cnt_val),
      .dec_i(cnt_dec), .zero_o(cnt_zero));

   assign tx_ok_o = (state_q == ST_OK);
   assign defer_o = (state_q == ST_WAIT) || (state_q == ST_PH0) ||
                    (state_q == ST_PH1)  || (state_q == ST_PH2);

   // R1: reset leaves the timer permitted and not deferring
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (tx_ok_o && !defer_o));

   // R2: permitted and deferring exclude each other
   a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(tx_ok_o && defer_o));

   // R2: carrier while permitted starts deferral
   a_r2_carrier_defers: assert property (@(posedge clk) disable iff (rst)
      (tx_ok_o && carrier_i) |=> (defer_o && !tx_ok_o));

   // R5: carrier in lead-in or deferring phase falls back to waiting
   a_r5_restart: assert property (@(posedge clk) disable iff (rst)
      ((state_q == ST_PH0 || state_q == ST_PH1) && carrier_i) |=> (state_q == ST_WAIT));

   // R6: carrier in committed phase never returns to waiting
   a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_PH2) |=> (state_q != ST_WAIT));

   // R8: starting a frame clears both outputs
   a_r8_tx_start: assert property (@(posedge clk) disable iff (rst)
      (tx_ok_o && !carrier_i && tx_req_i) |=> (!tx_ok_o && !defer_o));

   // R8: carrier is ignored while a frame is in progress
   a_r8_tx_hold: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_TX && tx_req_i) |=> (state_q == ST_TX));

   // R10: permission persists while the line stays quiet
   a_r10_persist: assert property (@(posedge clk) disable iff (rst)
      (tx_ok_o && !carrier_i && !tx_req_i) |=> tx_ok_o);

endmodule

// File: tb/ipg_defer_timer_bench.sv
`timescale 1ns/1ps
module ipg_defer_timer_bench;

   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst;
   logic carrier;
   logic [CNT_W-1:0] l0, l1, l2;
   logic mode, txreq;
   logic tx_ok, defer;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   ipg_defer_timer #(.CNT_W(CNT_W)) u_ipg_defer_timer (
      .clk(clk), .rst(rst), .carrier_i(carrier),
      .gap0_len_i(l0), .gap1_len_i(l1), .gap2_len_i(l2),
      .ext_mode_i(mode), .tx_req_i(txreq),
      .tx_ok_o(tx_ok), .defer_o(defer));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // carrier (or request) was just dropped at a negedge; count edges to permit
   task automatic measure(input int exp, input string tag);
      int n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end while (!tx_ok && n < 2000);
      chk(n == exp, tag, n, exp);
   endtask

   task automatic busy_then_drop();
      carrier = 1'b1;
      step(2);
      carrier = 1'b0;
   endtask

   initial begin
      rst = 1'b1; carrier = 1'b0; txreq = 1'b0; mode = 1'b1;
      l0 = 8'd1; l1 = 8'd1; l2 = 8'd1;
      step(3);
      // R1 reset state
      chk(tx_ok == 1'b1, "R1 tx_ok after reset", int'(tx_ok), 1);
      chk(defer == 1'b0, "R1 defer after reset", int'(defer), 0);
      rst = 1'b0;
      step(1);

      // R2 carrier while permitted
      carrier = 1'b1;
      step(1);
      chk(tx_ok == 1'b0, "R2 tx_ok on carrier", int'(tx_ok), 0);
      chk(defer == 1'b1, "R2 defer on carrier", int'(defer), 1);
      carrier = 1'b0;
      measure(4, "R3 first gap 1+1+1");

      // R3 R4 R7 sweep of all small lengths in both modes
      for (int m = 0; m < 2; m++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
               for (int c = 0; c < 4; c++) begin
                  mode = m[0]; l0 = 8'(a); l1 = 8'(b); l2 = 8'(c);
                  busy_then_drop();
                  measure((m == 1 ? a : 0) + b + c + 1,
                          m == 1 ? "R3 R7 sweep mode1" : "R4 R7 sweep mode0");
               end

      // R3 long mixed case
      mode = 1'b1; l0 = 8'd200; l1 = 8'd0; l2 = 8'd17;
      busy_then_drop();
      measure(218, "R3 long gap");

      // R5 carrier during lead-in
      mode = 1'b1; l0 = 8'd3; l1 = 8'd2; l2 = 8'd2;
      busy_then_drop();
      step(1);
      carrier = 1'b1;
      step(2);
      chk(defer == 1'b1, "R5 defer during lead-in carrier", int'(defer), 1);
      carrier = 1'b0;
      measure(8, "R5 restart from lead-in");

      // R5 carrier during deferring phase, mode 0
      mode = 1'b0; l0 = 8'd9; l1 = 8'd3; l2 = 8'd2;
      busy_then_drop();
      step(2);
      carrier = 1'b1;
      step(1);
      carrier = 1'b0;
      measure(6, "R5 restart from deferring phase");

      // R6 carrier during committed phase ignored
      mode = 1'b1; l0 = 8'd2; l1 = 8'd2; l2 = 8'd3;
      busy_then_drop();
      step(5);           // edges 1..5 done; state after edge 5 is committed phase
      carrier = 1'b1;
      step(1);           // sampled at edge 6
      carrier = 1'b0;
      chk(defer == 1'b1, "R6 still timing after carrier in committed phase", int'(defer), 1);
      begin
         int n = 6;
         while (!tx_ok && n < 100) begin
            @(posedge clk); n++; @(negedge clk);
         end
         chk(n == 8, "R6 original schedule kept", n, 8);
      end

      // R9 mode flip mid-gap, both directions
      mode = 1'b1; l0 = 8'd2; l1 = 8'd2; l2 = 8'd2;
      busy_then_drop();
      step(1);
      mode = 1'b0;
      measure(6, "R9 mode 1 to 0 mid-gap");
      busy_then_drop();
      step(1);
      mode = 1'b1;
      measure(4, "R9 mode 0 to 1 mid-gap");

      // R10 persistence
      step(20);
      chk(tx_ok == 1'b1, "R10 permit persists", int'(tx_ok), 1);

      // R8 transmit start, carrier ignored, gap after request falls
      mode = 1'b1; l0 = 8'd1; l1 = 8'd2; l2 = 8'd3;
      txreq = 1'b1;
      step(1);
      chk(tx_ok == 1'b0, "R8 tx_ok cleared on start", int'(tx_ok), 0);
      chk(defer == 1'b0, "R8 defer clear on start", int'(defer), 0);
      carrier = 1'b1;
      step(3);
      chk(defer == 1'b0, "R8 carrier ignored while sending", int'(defer), 0);
      carrier = 1'b0;
      step(1);
      txreq = 1'b0;
      measure(7, "R8 gap after request falls");

      // R2 mid-gap outputs exclusive
      busy_then_drop();
      step(1);
      chk(!(tx_ok && defer), "R2 outputs exclusive mid-gap", int'(tx_ok && defer), 0);
      step(10);

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule